// File: doc/BRIEF.md
# Multi-mode digital phase comparator

This block is the phase-comparison front end of a digital PLL. It takes two asynchronous single-bit inputs. The first is a reference signal. The second is a feedback signal from the oscillator or from a divider after it. The block resynchronises both inputs into one fast system clock, detects their rising edges, and produces three detector results in parallel. A loop filter, or software that models one, can then use whichever result suits the loop.

The three detectors differ in what they respond to:

- **Exclusive-OR detector.** It responds to input levels. Its average output is mid-scale at a quarter-period offset, and also mid-scale when no reference is present, so an idle loop settles at the centre frequency.
- **Phase/frequency detector.** It responds only to rising edges. It holds one "pump up" memory and one "pump down" memory. Its output is driven high for up, driven low for down, and released (output-enable low) when neither memory is set. A busy flag accompanies it and serves as a lock indicator: in lock the flag shows only short pulses.
- **Set/reset sequential detector.** It also responds only to rising edges. A reference edge sets it and a feedback edge clears it. Its average output is linear over a full period and is mid-scale at half a period of offset.

Input rates must stay below a quarter of the system clock.

Top module: `phase_cmp_trio`

## Requirements
- R1: A level change on either input reaches `xor_out` on the third rising clock edge after it is applied, so there are two synchroniser stages plus one output register.
- R2: `xor_out` equals the exclusive-OR of the synchronised reference and feedback levels.
- R3: A reference rising edge, while the down memory is clear, sets the up memory. The detector then shows `pfd_oe`=1 and `pfd_out`=1.
- R4: A feedback rising edge, while the up memory is clear, sets the down memory. The detector then shows `pfd_oe`=1 and `pfd_out`=0.
- R5: When both memories are set, both are cleared on the next clock. The settled result is `pfd_oe`=0 and `pfd_busy`=0. Rising edges on both inputs in the same cycle leave the detector released.
- R6: A rising edge that arrives in the clearing cycle of R5 is kept. It sets its own memory as the clear takes effect.
- R7: Falling edges have no effect on the phase/frequency detector or on the set/reset detector, so input duty cycle does not matter.
- R8: `pfd_busy` is high exactly while either memory is set, so it is high whenever `pfd_oe` is high.
- R9: A reference rising edge alone sets `rs_out` to 1. A feedback rising edge alone clears it to 0.
- R10: Rising edges on both inputs in the same cycle toggle `rs_out`.
- R11: A synchronous reset clears all state. During and right after reset, `xor_out`, `pfd_out`, `pfd_oe`, `pfd_busy` and `rs_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Reference input (asynchronous) |
| fb_in | input | 1 | Feedback input (asynchronous) |
| xor_out | output | 1 | Exclusive-OR detector result |
| pfd_out | output | 1 | Phase/frequency detector level: 1 means pump up, 0 means pump down; meaningful only when enabled |
| pfd_oe | output | 1 | Output enable of the phase/frequency detector; low means released |
| pfd_busy | output | 1 | High while either phase/frequency memory is set |
| rs_out | output | 1 | Set/reset sequential detector result |

## Verification
A stimulus table leads the reference, then leads the feedback, and then raises both inputs together. This pattern separates the up path from the down path, shows whether the cancelling clear happens, and shows whether the set/reset detector toggles rather than favouring one input. Falling-edge-only steps sit between the leading edges and expose any sensitivity to levels rather than edges. Directed cases cover the rest:

- an edge that lands exactly in the clearing cycle, which exposes a clear that swallows the edge;
- a cycle-exact latency probe on the level path;
- a reset applied in the middle of a pump-up state.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  // Memory pair of the phase/frequency detector.
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;

  // One clock step of the phase/frequency detector.
  // A set pair cancels, but edges seen in this cycle still land.
  function automatic pfd_state_t pfd_step(input pfd_state_t cur,
                                          input logic rise_ref,
                                          input logic rise_fb);
    pfd_state_t nxt;
    if (cur.up && cur.dn) begin
      nxt.up = rise_ref;
      nxt.dn = rise_fb;
    end else begin
      nxt.up = cur.up | rise_ref;
      nxt.dn = cur.dn | rise_fb;
    end
    return nxt;
  endfunction

  // One clock step of the set/reset sequential detector.
  function automatic logic rs_step(input logic q,
                                   input logic set_e,
                                   input logic clr_e);
    logic r;
    unique case ({set_e, clr_e})
      2'b11:   r = ~q;
      2'b10:   r = 1'b1;
      2'b01:   r = 1'b0;
      default: r = q;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcmp_edge_sync.sv
module pcmp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[LAST];
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev_q;
endmodule

// File: rtl/pcmp_xor_det.sv
module pcmp_xor_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_ref,
  input  logic lvl_fb,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= lvl_ref ^ lvl_fb;
  end
endmodule

// File: rtl/pcmp_pfd.sv
module pcmp_pfd
  import pcmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_ref,
  input  logic rise_fb,
  output logic up_q,
  output logic dn_q,
  output logic drive,
  output logic oe,
  output logic busy
);
  pfd_state_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= pfd_step(st, rise_ref, rise_fb);
  end

  assign up_q  = st.up;
  assign dn_q  = st.dn;
  assign oe    = st.up ^ st.dn;
  assign drive = st.up & ~st.dn;
  assign busy  = st.up | st.dn;
endmodule

// File: rtl/pcmp_rs_det.sv
module pcmp_rs_det
  import pcmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_ref,
  input  logic rise_fb,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= rs_step(q, rise_ref, rise_fb);
  end
endmodule

// File: rtl/phase_cmp_trio.sv
module phase_cmp_trio #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  input  logic fb_in,
  output logic xor_out,
  output logic pfd_out,
  output logic pfd_oe,
  output logic pfd_busy,
  output logic rs_out
);
  // Internal events, named so that the bound checker can reach them.
  logic sig_lvl, fb_lvl;
  logic sig_rise, fb_rise;
  logic pfd_up, pfd_dn;

  pcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk(clk), .rst(rst), .din(sig_in), .level(sig_lvl), .rise(sig_rise)
  );

  pcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
    .clk(clk), .rst(rst), .din(fb_in), .level(fb_lvl), .rise(fb_rise)
  );

  pcmp_xor_det u_xor (
    .clk(clk), .rst(rst), .lvl_ref(sig_lvl), .lvl_fb(fb_lvl), .q(xor_out)
  );

  pcmp_pfd u_pfd (
    .clk(clk), .rst(rst), .rise_ref(sig_rise), .rise_fb(fb_rise),
    .up_q(pfd_up), .dn_q(pfd_dn), .drive(pfd_out), .oe(pfd_oe),
    .busy(pfd_busy)
  );

  pcmp_rs_det u_rs (
    .clk(clk), .rst(rst), .rise_ref(sig_rise), .rise_fb(fb_rise), .q(rs_out)
  );
endmodule

// File: rtl/phase_cmp_trio_chk.sv
module phase_cmp_trio_chk (
  input logic clk,
  input logic rst,
  input logic sig_rise,
  input logic fb_rise,
  input logic pfd_up,
  input logic pfd_dn,
  input logic pfd_out,
  input logic pfd_oe,
  input logic pfd_busy,
  input logic rs_out,
  input logic xor_out
);
  p_up_set_r3: assert property (@(posedge clk) disable iff (rst)
    (sig_rise && !fb_rise && !pfd_dn) |=> (pfd_oe && pfd_out));

  p_dn_set_r4: assert property (@(posedge clk) disable iff (rst)
    (fb_rise && !sig_rise && !pfd_up) |=> (pfd_oe && !pfd_out));

  p_both_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (pfd_up && pfd_dn) |=> !(pfd_up && pfd_dn));

  p_keep_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (pfd_up && pfd_dn && sig_rise && !fb_rise) |=> (pfd_up && !pfd_dn));

  p_oe_busy_r8: assert property (@(posedge clk) disable iff (rst)
    pfd_oe |-> pfd_busy);

  p_rs_set_r9: assert property (@(posedge clk) disable iff (rst)
    (sig_rise && !fb_rise) |=> rs_out);

  p_rs_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (fb_rise && !sig_rise) |=> !rs_out);

  p_rs_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    (sig_rise && fb_rise) |=> (rs_out != $past(rs_out)));

  p_reset_out_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pfd_oe && !pfd_busy && !rs_out && !xor_out));
endmodule

bind phase_cmp_trio phase_cmp_trio_chk u_chk (
  .clk(clk), .rst(rst), .sig_rise(sig_rise), .fb_rise(fb_rise),
  .pfd_up(pfd_up), .pfd_dn(pfd_dn), .pfd_out(pfd_out), .pfd_oe(pfd_oe),
  .pfd_busy(pfd_busy), .rs_out(rs_out), .xor_out(xor_out)
);

// File: tb/test_phase_cmp_trio.sv
`timescale 1ns/1ps
module test_phase_cmp_trio;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic fb_in = 1'b0;
  logic xor_out, pfd_out, pfd_oe, pfd_busy, rs_out;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  phase_cmp_trio i_phase_cmp_trio (
    .clk(clk), .rst(rst), .sig_in(sig_in), .fb_in(fb_in),
    .xor_out(xor_out), .pfd_out(pfd_out), .pfd_oe(pfd_oe),
    .pfd_busy(pfd_busy), .rs_out(rs_out)
  );

  // Vector: {sig, fb, exp_xor, exp_rs, exp_oe, exp_lvl, exp_busy}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b10_1_1_1_1_1,  // R3 ref leads: up, rs set
    7'b00_0_1_1_1_1,  // R7 ref falls: no change
    7'b01_1_0_0_0_0,  // R5 fb edge cancels up; R9 rs cleared
    7'b00_0_0_0_0_0,  // R7
    7'b01_1_0_1_0_1,  // R4 fb leads: down
    7'b00_0_0_1_0_1,  // R7 down held over fall
    7'b10_1_1_0_0_0,  // R5 ref cancels down; R9 rs set
    7'b11_0_0_1_0_1,  // R4 fb edge: down; R9 rs cleared
    7'b00_0_0_1_0_1,  // R7
    7'b11_0_1_0_0_0,  // R10 both edges: rs toggles 0->1; R5 cancel
    7'b00_0_1_0_0_0,  // R7
    7'b11_0_0_0_0_0,  // R10 toggles 1->0; R5 simultaneous stays released
    7'b00_0_0_0_0_0   // R2 both low
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk_all(input string req, input logic ex, input logic er,
                         input logic eo, input logic el, input logic eb);
    chk(req, "xor_out", xor_out, ex);
    chk(req, "rs_out", rs_out, er);
    chk(req, "pfd_oe", pfd_oe, eo);
    if (eo) chk(req, "pfd_out", pfd_out, el);
    chk(req, "pfd_busy", pfd_busy, eb);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    wait_neg(3);
    chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R11 during reset
    rst = 1'b0;
    wait_neg(1);
    chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R11 just after release

    for (int i = 0; i < NV; i++) begin
      sig_in = VEC[i][6];
      fb_in  = VEC[i][5];
      wait_neg(4);
      chk_all($sformatf("R2/vec%0d", i), VEC[i][4], VEC[i][3],
              VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6: an edge in the clearing cycle must survive.
    sig_in = 1'b1; wait_neg(4);
    sig_in = 1'b0; wait_neg(4);        // up memory set, ref low again
    fb_in  = 1'b1; wait_neg(1);        // fb edge cancels one cycle later...
    sig_in = 1'b1;                     // ...and the ref edge lands in the clear
    wait_neg(5);
    chk("R6", "pfd_oe", pfd_oe, 1'b1);
    chk("R6", "pfd_out", pfd_out, 1'b1);
    chk("R6", "pfd_busy", pfd_busy, 1'b1);
    chk("R9", "rs_out", rs_out, 1'b1);

    // R1: exact latency on the level path.
    sig_in = 1'b0; fb_in = 1'b0; wait_neg(4);
    chk("R7", "pfd_oe", pfd_oe, 1'b1);  // falling edges leave up set
    sig_in = 1'b1;
    wait_neg(2);
    chk("R1", "xor_out@2", xor_out, 1'b0);
    wait_neg(1);
    chk("R1", "xor_out@3", xor_out, 1'b1);

    // R11: reset in the middle of a pump-up state.
    sig_in = 1'b0;
    rst = 1'b1;
    wait_neg(1);
    chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_neg(3);
    rst = 1'b0;
    wait_neg(4);
    chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule